// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block drives the command strobes and clock enable of every SDRAM channel on a memory bus controller. It handles only the moves into and out of self-refresh. A single level-sensitive request bit, normally held in a control register, chooses the target state. When the bit goes high while the devices are active, the block issues a protective auto-refresh and then a deselect wait of programmable length. It then issues the self-refresh entry command in the same cycle that it drops CKE. When the bit goes low while the devices are in self-refresh, the block raises CKE under a deselect command. It waits a programmable recovery time, issues a further auto-refresh, and waits the auto-refresh interval once more before it goes idle.

All channels share one sequence, so every chip select and every CKE switches in the same cycle. A change of the request bit during a sequence is not lost. The current sequence runs to its end, and the block then compares the bit with the state of the devices. Entry and exit therefore never interleave. A busy output and a self-refresh status output let the surrounding controller hold off normal traffic.

Top module: `sdram_sr_seq`

## Requirements
- R1: After reset, every `cs_n` bit, `ras_n`, `cas_n` and `we_n` are 1, every `cke` bit is 1, and `busy` and `in_sr` are 0.
- R2: Command encoding: deselect has every `cs_n`=1 and `{ras_n,cas_n,we_n}`=3'b111. Auto-refresh has every `cs_n`=0 and `{ras_n,cas_n,we_n}`=3'b001. With the devices active and idle, a high `sr_req` sampled at a clock edge makes the next cycle an auto-refresh with `cke` high.
- R3: After each auto-refresh, deselect is driven for exactly max(`refresh_wait`,1) cycles.
- R4: After the entry wait, one cycle carries the auto-refresh encoding with every `cke` low (entry command). After that, `cke` stays low, deselect is driven and `in_sr` is 1 until exit begins.
- R5: In self-refresh, a low `sr_req` sampled at a clock edge makes the next cycle a deselect with every `cke` high and `in_sr` 0.
- R6: After the exit command, deselect is driven for max(`recover_wait`,1) cycles. One auto-refresh follows, then the R3 wait, then idle deselect.
- R7: A wait setting of zero gives a one-cycle wait, both for `refresh_wait` and for `recover_wait`.
- R8: `busy` is 1 in every cycle from the first auto-refresh of entry through the entry command, and from the exit command through the last exit wait cycle. It is 0 while idle and while in self-refresh.
- R9: A change of `sr_req` during a sequence does not cut that sequence short. It takes effect only once the sequence has completed.
- R10: All channels carry identical `cs_n` and `cke` values in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_req | input | 1 | 1 requests self-refresh, 0 requests normal operation |
| refresh_wait | input | DW | Deselect cycles after each auto-refresh (0 counts as 1) |
| recover_wait | input | RW | Deselect cycles after the exit command (0 counts as 1) |
| cs_n | output | NCH | Chip select per channel, active low |
| ras_n | output | 1 | Shared row strobe, active low |
| cas_n | output | 1 | Shared column strobe, active low |
| we_n | output | 1 | Shared write enable, active low |
| cke | output | NCH | Clock enable per channel |
| busy | output | 1 | A sequence is in progress |
| in_sr | output | 1 | Devices are held in self-refresh |

## Verification
The embedded properties check the ordering rules on every cycle. They cover the following:
- the entry command only after an entry wait, and the closing auto-refresh only after the recovery wait;
- CKE falling only together with the refresh encoding, and rising only under deselect;
- no underflow of the wait counter;
- `busy` and `in_sr` never high together.

The exact wait lengths, including the zero-as-one rule, the reset values, and the deferred handling of a request that changes during a sequence are shown only by the bench's scenarios. The bench sweeps every pair of small wait settings and compares each cycle of the traces against an arithmetic model.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_EN_RFA  = 4'd1,
    ST_EN_WAIT = 4'd2,
    ST_EN_RFS  = 4'd3,
    ST_SELF    = 4'd4,
    ST_EX_RFX  = 4'd5,
    ST_EX_REX  = 4'd6,
    ST_EX_RFA  = 4'd7,
    ST_EX_WAIT = 4'd8
  } sr_state_e;

  localparam logic [2:0] RCW_DSL = 3'b111;
  localparam logic [2:0] RCW_REF = 3'b001;
endpackage

// File: rtl/sr_wait_timer.sv
module sr_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  output logic          expire
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = run & (cnt_q == TW'(1));

  // R3 / R6: a wait phase never sees an exhausted counter
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
  import sr_pkg::*;
#(
  parameter int DW = 4,
  parameter int RW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sr_req,
  input  logic [DW-1:0] refresh_wait,
  input  logic [RW-1:0] recover_wait,
  input  logic          expire,
  output sr_state_e     state_q,
  output sr_state_e     state_d,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_run
);
  logic [TW-1:0] ref_len;
  logic [TW-1:0] rec_len;

  always_comb begin
    ref_len = (refresh_wait == '0) ? TW'(1) : TW'(refresh_wait);
    rec_len = (recover_wait == '0) ? TW'(1) : TW'(recover_wait);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (sr_req) state_d = ST_EN_RFA;
      ST_EN_RFA:  state_d = ST_EN_WAIT;
      ST_EN_WAIT: if (expire) state_d = ST_EN_RFS;
      ST_EN_RFS:  state_d = ST_SELF;
      ST_SELF:    if (!sr_req) state_d = ST_EX_RFX;
      ST_EX_RFX:  state_d = ST_EX_REX;
      ST_EX_REX:  if (expire) state_d = ST_EX_RFA;
      ST_EX_RFA:  state_d = ST_EX_WAIT;
      ST_EX_WAIT: if (expire) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_q == ST_EN_RFA) | (state_q == ST_EX_RFA) |
               (state_q == ST_EX_RFX);
    tmr_val  = (state_q == ST_EX_RFX) ? rec_len : ref_len;
    tmr_run  = (state_q == ST_EN_WAIT) | (state_q == ST_EX_REX) |
               (state_q == ST_EX_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R4: the entry command only follows a completed entry wait
  a_r4_rfs_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EN_RFS) |-> ($past(state_q) == ST_EN_WAIT));
  // R6: the closing refresh only follows the recovery wait
  a_r6_rfa_after_rex: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EX_RFA) |-> ($past(state_q) == ST_EX_REX));
  // R9: an entry wait never branches into the exit path
  a_r9_entry_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EN_WAIT) |=> ((state_q == ST_EN_WAIT) || (state_q == ST_EN_RFS)));
endmodule

// File: rtl/sr_cmd_drive.sv
module sr_cmd_drive
  import sr_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  sr_state_e      state_d,
  output logic [NCH-1:0] cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [NCH-1:0] cke,
  output logic           busy,
  output logic           in_sr
);
  logic       cs_nx;
  logic       cke_nx;
  logic [2:0] rcw_nx;
  logic       busy_nx;
  logic       insr_nx;
  logic [2:0] rcw_q;

  always_comb begin
    cs_nx   = 1'b1;
    rcw_nx  = RCW_DSL;
    cke_nx  = 1'b1;
    busy_nx = 1'b1;
    insr_nx = 1'b0;
    unique case (state_d)
      ST_IDLE:   busy_nx = 1'b0;
      ST_EN_RFA,
      ST_EX_RFA: begin cs_nx = 1'b0; rcw_nx = RCW_REF; end
      ST_EN_RFS: begin cs_nx = 1'b0; rcw_nx = RCW_REF; cke_nx = 1'b0; end
      ST_SELF:   begin cke_nx = 1'b0; busy_nx = 1'b0; insr_nx = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcw_q <= RCW_DSL;
      busy  <= 1'b0;
      in_sr <= 1'b0;
    end else begin
      rcw_q <= rcw_nx;
      busy  <= busy_nx;
      in_sr <= insr_nx;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cs_n[g] <= 1'b1;
        cke[g]  <= 1'b1;
      end else begin
        cs_n[g] <= cs_nx;
        cke[g]  <= cke_nx;
      end
    end
  end

  assign {ras_n, cas_n, we_n} = rcw_q;

  // R4: CKE only falls together with the refresh encoding
  a_r4_cke_fall_with_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke[0]) |-> (!cs_n[0] && ({ras_n, cas_n, we_n} == RCW_REF)));
  // R4: self-refresh status implies CKE low on every channel
  a_r4_insr_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> (cke == '0));
  // R5: CKE only rises under deselect
  a_r5_cke_rise_dsl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke[0]) |-> (cs_n == '1));
  // R8: never busy and in self-refresh at once
  a_r8_busy_excl_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && in_sr));
endmodule

// File: rtl/sdram_sr_seq.sv
module sdram_sr_seq
  import sr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 4,
  parameter int RW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sr_req,
  input  logic [DW-1:0]  refresh_wait,
  input  logic [RW-1:0]  recover_wait,
  output logic [NCH-1:0] cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [NCH-1:0] cke,
  output logic           busy,
  output logic           in_sr
);
  localparam int TW = (DW > RW) ? DW : RW;

  sr_state_e     state_q;
  sr_state_e     state_d;
  logic          tmr_load;
  logic          tmr_run;
  logic          expire;
  logic [TW-1:0] tmr_val;

  sr_seq_fsm #(.DW(DW), .RW(RW), .TW(TW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sr_req       (sr_req),
    .refresh_wait (refresh_wait),
    .recover_wait (recover_wait),
    .expire       (expire),
    .state_q      (state_q),
    .state_d      (state_d),
    .tmr_load     (tmr_load),
    .tmr_val      (tmr_val),
    .tmr_run      (tmr_run)
  );

  sr_wait_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expire   (expire)
  );

  sr_cmd_drive #(.NCH(NCH)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .cke     (cke),
    .busy    (busy),
    .in_sr   (in_sr)
  );
endmodule

// File: tb/sdram_sr_seq_test.sv
module sdram_sr_seq_test;
  localparam int NCH = 2;
  localparam int DW  = 4;
  localparam int RW  = 8;

  logic           clk;
  logic           rst_n;
  logic           sr_req;
  logic [DW-1:0]  refresh_wait;
  logic [RW-1:0]  recover_wait;
  logic [NCH-1:0] cs_n;
  logic           ras_n, cas_n, we_n;
  logic [NCH-1:0] cke;
  logic           busy, in_sr;

  int n_cmp = 0;
  int n_bad = 0;

  sdram_sr_seq #(.NCH(NCH), .DW(DW), .RW(RW)) uut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req),
    .refresh_wait(refresh_wait), .recover_wait(recover_wait),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .busy(busy), .in_sr(in_sr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic e_cs, input logic [2:0] e_rcw,
                       input logic e_cke, input logic e_busy, input logic e_sr);
    logic [NCH*2+5-1:0] act, exp;
    act = {cs_n, ras_n, cas_n, we_n, cke, busy, in_sr};
    exp = {{NCH{e_cs}}, e_rcw, {NCH{e_cke}}, e_busy, e_sr};
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t {cs_n,rcw,cke,busy,in_sr} actual=%b expected=%b",
               req, $time, act, exp);
    end
  endtask

  // DSL = cs 1 / 111, REF = cs 0 / 001 (R2)
  task automatic exp_dsl(input string req, input logic e_cke, input logic e_busy,
                         input logic e_sr);
    @(negedge clk); check(req, 1'b1, 3'b111, e_cke, e_busy, e_sr);
  endtask

  task automatic exp_entry(input int d, input bit drop_early);
    int nd;
    nd = (d == 0) ? 1 : d;
    @(negedge clk); check("R2 entry RFA", 1'b0, 3'b001, 1'b1, 1'b1, 1'b0);
    if (drop_early) sr_req = 1'b0;   // R9 request withdrawn mid-entry
    for (int i = 0; i < nd; i++) exp_dsl("R3 R7 entry wait", 1'b1, 1'b1, 1'b0);
    @(negedge clk); check("R4 R8 entry command", 1'b0, 3'b001, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic exp_exit(input int d, input int r);
    int nd, nr;
    nd = (d == 0) ? 1 : d;
    nr = (r == 0) ? 1 : r;
    exp_dsl("R5 exit command", 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < nr; i++) exp_dsl("R6 R7 recovery wait", 1'b1, 1'b1, 1'b0);
    @(negedge clk); check("R6 exit RFA", 1'b0, 3'b001, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < nd; i++) exp_dsl("R3 R6 exit wait", 1'b1, 1'b1, 1'b0);
    exp_dsl("R6 R8 idle after exit", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; sr_req = 1'b0; refresh_wait = '0; recover_wait = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b1, 3'b111, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    exp_dsl("R1 idle", 1'b1, 1'b0, 1'b0);

    // Sweep wait settings, including zero (R7); channels compared together (R10)
    for (int d = 0; d < 4; d++) begin
      for (int r = 0; r < 4; r++) begin
        refresh_wait = DW'(d);
        recover_wait = RW'(r);
        sr_req = 1'b1;
        exp_entry(d, 1'b0);
        for (int k = 0; k < 3; k++) exp_dsl("R4 R10 in self-refresh", 1'b0, 1'b0, 1'b1);
        sr_req = 1'b0;
        exp_exit(d, r);
        exp_dsl("R8 idle", 1'b1, 1'b0, 1'b0);
      end
    end

    // R9: request dropped during entry; entry completes, then exit follows
    refresh_wait = 4'd3; recover_wait = 8'd2;
    sr_req = 1'b1;
    exp_entry(3, 1'b1);
    exp_dsl("R9 one self-refresh cycle", 1'b0, 1'b0, 1'b1);
    exp_exit(3, 2);

    // R9: request raised during exit; exit completes, then entry restarts
    sr_req = 1'b1;
    exp_entry(2'd3, 1'b0);
    exp_dsl("R9 in self-refresh", 1'b0, 1'b0, 1'b1);
    sr_req = 1'b0;
    exp_dsl("R5 exit command", 1'b1, 1'b1, 1'b0);
    sr_req = 1'b1;
    exp_dsl("R9 recovery wait 1", 1'b1, 1'b1, 1'b0);
    exp_dsl("R9 recovery wait 2", 1'b1, 1'b1, 1'b0);
    @(negedge clk); check("R9 exit RFA", 1'b0, 3'b001, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) exp_dsl("R9 exit wait", 1'b1, 1'b1, 1'b0);
    exp_dsl("R9 idle one cycle", 1'b1, 1'b0, 1'b0);
    exp_entry(3, 1'b0);
    exp_dsl("R9 re-entered", 1'b0, 1'b0, 1'b1);
    sr_req = 1'b0;
    exp_exit(3, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule